// File: doc/BRIEF.md
# Parallel Bit-Slice Lookup FIR Filter

This block is a finite impulse response filter with a fixed set of coefficients. It needs no multiplier. It keeps the most recent `N_TAPS` signed samples in a shift register. At one bit position `m`, the bits of all stored samples form an address. That address selects a precomputed sum of the coefficients whose samples carry a one at that position. All `W` bit positions are looked up at the same time, each in its own table. A tree of adders then merges the `W` partial sums. At every level of the tree, the more significant operand is shifted left. The output is one exact result per accepted sample.

The table for the sign bit position holds negated sums, so two's-complement samples need no correction step. The parameter `K` selects a split table. When `K` is below `N_TAPS`, each address is cut into groups of `K` bits, and each group has its own table of `2^K` entries. The group results are added to give the slice sum. The parameter `PIPE` adds a register after the lookups, which shortens the logic path at the cost of one more cycle of latency.

Samples and coefficients are read as integers. The output therefore has no fraction bits of its own. If the samples carry `fs` fraction bits and the coefficients carry `fc`, the binary point of `out_y` sits `fs + fc` bits above bit 0.

Top module: `da_fir`

## Requirements
- R1: While `rst` is high at a rising edge, `out_valid` goes low, `out_y` goes to 0 and every stored sample goes to zero. The first output after reset therefore equals `a(0)·x` for the first accepted sample `x`.
- R2: Each rising edge with `in_valid` high accepts `in_x` and produces exactly one single-cycle `out_valid` pulse. The pulse comes `2 + PIPE` rising edges later, and this also holds when samples arrive on consecutive cycles.
- R3: With the pulse, `out_y = Σ a(k)·x(n−k)` for `k = 0..N_TAPS−1`. Tap 0 is the newest sample. The coefficient `a(k)` sits in bits `[k·CW +: CW]` of `COEFS`. Bit `m` of tap `k` drives address bit `k` of table `m`.
- R4: A rising edge with `in_valid` low leaves the stored samples unchanged, so the value on `in_x` at that edge has no effect on any later output.
- R5: The result is exact for the most negative sample (−2^(W−1)) and the most negative coefficient. `|out_y|` never exceeds `N_TAPS·2^(CW−1)·2^(W−1)`.
- R6: A split table (`K < N_TAPS`, `K` dividing `N_TAPS`) yields the same `out_y` sequence as the unsplit table.
- R7: Table entry 0 is zero, so an all-zero history gives `out_y = 0`.
- R8: `out_y` changes only on a cycle where `out_valid` is high, and it holds its value between pulses.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Accepts `in_x` at this edge |
| in_x | input | W | Two's-complement sample |
| out_valid | output | 1 | One-cycle pulse marking a new result |
| out_y | output | CW+W+clog2(N_TAPS) | Signed filter result, integer scaled |

## Verification
The bench builds two copies of the block with 4 taps, 8-bit samples and 8-bit coefficients that include −128. The first copy uses one 16-entry table per slice and no pipeline register. The second copy splits each address into two groups of 2 bits and adds the pipeline register. Both copies see the same stimulus. This covers both table layouts and both latencies, and it compares the split result against a direct multiply-accumulate model. The −128 by −128 product reaches the negated sign-bit table and the widest sums.

// File: rtl/da_fir_pkg.sv
package da_fir_pkg;

    // Polarity of a slice table: sign-bit slice holds negated sums.
    typedef enum logic {
        SLICE_POS = 1'b0,
        SLICE_NEG = 1'b1
    } slice_sign_e;

    // Width of one slice sum: room for N coefficients plus negation.
    function automatic int slice_w(int n, int cw);
        return cw + $clog2(n) + 1;
    endfunction

    // Width of the full-precision result.
    function automatic int out_w(int n, int w, int cw);
        return cw + w + $clog2(n);
    endfunction

endpackage

// File: rtl/da_fir_taps.sv
module da_fir_taps #(
    parameter int N_TAPS = 4,
    parameter int W      = 8
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  in_valid,
    input  logic [W-1:0]          in_x,
    output logic [N_TAPS*W-1:0]   taps
);
    // tap 0 (newest) in the low W bits
    always_ff @(posedge clk) begin
        if (rst) begin
            taps <= '0;
        end else if (in_valid) begin
            taps <= {taps[(N_TAPS-1)*W-1:0], in_x};
        end
    end

    // R4
    hold_when_idle_chk: assert property (@(posedge clk) disable iff (rst)
        !in_valid |=> $stable(taps));

endmodule

// File: rtl/da_fir_slice.sv
module da_fir_slice
    import da_fir_pkg::*;
#(
    parameter int                  N_TAPS = 4,
    parameter int                  CW     = 8,
    parameter int                  K      = 4,
    parameter int                  SW     = 11,
    parameter slice_sign_e         SIGN   = SLICE_POS,
    parameter logic [N_TAPS*CW-1:0] COEFS = '0
) (
    input  logic [N_TAPS-1:0]     addr,
    output logic signed [SW-1:0]  sum
);
    localparam int GROUPS = N_TAPS / K;
    localparam int DEPTH  = 1 << K;

    // Sum of the coefficients of group g selected by the bits of e.
    function automatic logic signed [SW-1:0] entry(int g, int e);
        logic signed [SW-1:0] acc;
        acc = '0;
        for (int j = 0; j < K; j++) begin
            if (((e >> j) & 1) != 0) begin
                acc = acc + SW'(signed'(COEFS[(g*K+j)*CW +: CW]));
            end
        end
        return (SIGN == SLICE_NEG) ? -acc : acc;
    endfunction

    logic signed [SW-1:0] grp [GROUPS];

    for (genvar g = 0; g < GROUPS; g++) begin : g_grp
        logic signed [SW-1:0] tbl [DEPTH];
        for (genvar e = 0; e < DEPTH; e++) begin : g_ent
            assign tbl[e] = entry(g, e);
        end
        assign grp[g] = tbl[addr[g*K +: K]];
    end

    always_comb begin
        sum = '0;
        for (int g = 0; g < GROUPS; g++) begin
            sum = sum + grp[g];
        end
    end

    // R7
    always_comb begin
        if (addr == '0) begin
            zero_entry_chk: assert (sum == '0);
        end
    end

endmodule

// File: rtl/da_fir_tree.sv
module da_fir_tree #(
    parameter int W  = 8,
    parameter int SW = 11,
    parameter int OW = 18
) (
    input  logic [W*SW-1:0]       slices,
    output logic signed [OW-1:0]  y
);
    localparam int LV = $clog2(W);
    localparam int WP = 1 << LV;

    // Level l merges pairs as hi * 2^(2^(l-1)) + lo.
    for (genvar l = 0; l <= LV; l++) begin : lvl
        localparam int CNT = WP >> l;
        logic signed [OW-1:0] v [CNT];
        for (genvar j = 0; j < CNT; j++) begin : nd
            if (l == 0) begin : leaf
                if (j < W) begin : real_slice
                    assign v[j] = OW'(signed'(slices[j*SW +: SW]));
                end else begin : pad_slice
                    assign v[j] = '0;
                end
            end else begin : merge
                assign v[j] = (lvl[l-1].v[2*j+1] <<< (1 << (l-1)))
                            + lvl[l-1].v[2*j];
            end
        end
    end

    assign y = lvl[LV].v[0];

endmodule

// File: rtl/da_fir.sv
module da_fir
    import da_fir_pkg::*;
#(
    parameter int                    N_TAPS = 4,
    parameter int                    W      = 8,
    parameter int                    CW     = 8,
    parameter int                    K      = 4,
    parameter bit                    PIPE   = 1'b0,
    parameter logic [N_TAPS*CW-1:0]  COEFS  = {8'hFD, 8'h7F, 8'h80, 8'h05},
    localparam int                   OUT_W  = out_w(N_TAPS, W, CW)
) (
    input  logic                     clk,
    input  logic                     rst,
    input  logic                     in_valid,
    input  logic [W-1:0]             in_x,
    output logic                     out_valid,
    output logic signed [OUT_W-1:0]  out_y
);
    localparam int SW  = slice_w(N_TAPS, CW);
    localparam int LAT = 2 + int'(PIPE);
    localparam logic signed [OUT_W-1:0] Y_BOUND = OUT_W'(N_TAPS) << (CW + W - 2);

    logic [N_TAPS*W-1:0]         taps;
    logic [W-1:0][N_TAPS-1:0]    slice_addr;
    logic [W*SW-1:0]             slice_d;
    logic [W*SW-1:0]             slice_q;
    logic signed [OUT_W-1:0]     tree_y;
    logic [LAT-1:0]              vchain;

    da_fir_taps #(.N_TAPS(N_TAPS), .W(W)) u_taps (
        .clk      (clk),
        .rst      (rst),
        .in_valid (in_valid),
        .in_x     (in_x),
        .taps     (taps)
    );

    for (genvar m = 0; m < W; m++) begin : g_slice
        for (genvar k = 0; k < N_TAPS; k++) begin : g_bit
            assign slice_addr[m][k] = taps[k*W + m];
        end
        logic signed [SW-1:0] s;
        da_fir_slice #(
            .N_TAPS (N_TAPS),
            .CW     (CW),
            .K      (K),
            .SW     (SW),
            .SIGN   ((m == W-1) ? SLICE_NEG : SLICE_POS),
            .COEFS  (COEFS)
        ) u_slice (
            .addr (slice_addr[m]),
            .sum  (s)
        );
        assign slice_d[m*SW +: SW] = s;
    end

    if (PIPE) begin : g_pipe
        always_ff @(posedge clk) begin
            if (rst) begin
                slice_q <= '0;
            end else if (vchain[0]) begin
                slice_q <= slice_d;
            end
        end
    end else begin : g_flat
        assign slice_q = slice_d;
    end

    da_fir_tree #(.W(W), .SW(SW), .OW(OUT_W)) u_tree (
        .slices (slice_q),
        .y      (tree_y)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            vchain <= '0;
            out_y  <= '0;
        end else begin
            vchain <= {vchain[LAT-2:0], in_valid};
            if (vchain[LAT-2]) begin
                out_y <= tree_y;
            end
        end
    end

    assign out_valid = vchain[LAT-1];

    // R1
    reset_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (!out_valid && out_y == '0));

    // R2
    valid_latency_chk: assert property (@(posedge clk) disable iff (rst)
        out_valid |-> $past(in_valid, LAT));

    // R5
    no_overflow_chk: assert property (@(posedge clk) disable iff (rst)
        out_valid |-> (out_y <= Y_BOUND && out_y >= -Y_BOUND));

    // R8
    hold_between_chk: assert property (@(posedge clk) disable iff (rst)
        !$stable(out_y) |-> out_valid);

endmodule

// File: tb/test_da_fir.sv
module test_da_fir;
    localparam int CLK_PERIOD = 10;
    localparam int OW = 18;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic in_valid = 1'b0;
    logic [7:0] in_x = '0;
    logic a_valid, b_valid;
    logic signed [OW-1:0] a_y, b_y;

    int checks = 0;
    int errors = 0;
    int coef [4] = '{5, -128, 127, -3};
    int hist [4] = '{0, 0, 0, 0};
    int qa [$];
    int qb [$];

    always #(CLK_PERIOD/2) clk = ~clk;

    da_fir #(.K(4), .PIPE(1'b0)) i_da_fir (
        .clk(clk), .rst(rst), .in_valid(in_valid), .in_x(in_x),
        .out_valid(a_valid), .out_y(a_y)
    );

    da_fir #(.K(2), .PIPE(1'b1)) i_da_fir_split (
        .clk(clk), .rst(rst), .in_valid(in_valid), .in_x(in_x),
        .out_valid(b_valid), .out_y(b_y)
    );

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // Scoreboard: every pulse must match the multiply-accumulate model (R3, R6)
    always @(negedge clk) begin
        if (!rst) begin
            if (a_valid) begin
                if (qa.size() == 0) check(1'b0, "R2 unexpected pulse", 1, 0);
                else begin
                    automatic int e = qa.pop_front();
                    check(int'(a_y) == e, "R3 unsplit result", int'(a_y), e);
                end
            end
            if (b_valid) begin
                if (qb.size() == 0) check(1'b0, "R2 unexpected pulse split", 1, 0);
                else begin
                    automatic int e = qb.pop_front();
                    check(int'(b_y) == e, "R6 split result", int'(b_y), e);
                end
            end
        end
    end

    task automatic push(input logic [7:0] x);
        int y;
        @(negedge clk);
        in_valid = 1'b1;
        in_x = x;
        for (int k = 3; k > 0; k--) hist[k] = hist[k-1];
        hist[0] = int'($signed(x));
        y = 0;
        for (int k = 0; k < 4; k++) y += coef[k] * hist[k];
        qa.push_back(y);
        qb.push_back(y);
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            in_valid = 1'b0;
            in_x = 8'($urandom);
        end
    endtask

    task automatic t_reset_state();
        repeat (3) @(negedge clk);
        check(a_valid == 1'b0, "R1 valid low in reset", int'(a_valid), 0);
        check(b_valid == 1'b0, "R1 split valid low in reset", int'(b_valid), 0);
        rst = 1'b0;
        @(negedge clk);
        check(a_y == '0, "R1 output zero", int'(a_y), 0);
        check(b_y == '0, "R1 split output zero", int'(b_y), 0);
        push(8'd1);   // expect a(0)
        idle(4);
    endtask

    task automatic t_latency();
        push(8'd37);
        for (int i = 1; i <= 4; i++) begin
            @(negedge clk);
            in_valid = 1'b0;
            check(a_valid == (i == 2), "R2 latency unsplit", int'(a_valid), int'(i == 2));
            check(b_valid == (i == 3), "R2 latency split", int'(b_valid), int'(i == 3));
        end
    endtask

    task automatic t_hold();
        logic signed [OW-1:0] ya, yb;
        idle(4);
        ya = a_y;
        yb = b_y;
        for (int i = 0; i < 6; i++) begin
            idle(1);   // in_x toggles without in_valid (R4)
            check(a_y == ya, "R8 output held", int'(a_y), int'(ya));
            check(b_y == yb, "R8 split output held", int'(b_y), int'(yb));
        end
        push(8'd9);    // model history untouched by idle in_x: R4
        idle(4);
    endtask

    task automatic t_extremes();
        for (int i = 0; i < 4; i++) push(8'h80);   // R5 most negative
        idle(4);
        for (int i = 0; i < 4; i++) push(8'h7F);
        push(8'h80);
        push(8'hFF);
        idle(4);
    endtask

    task automatic t_zero();
        for (int i = 0; i < 4; i++) push(8'h00);   // R7 all-zero history
        idle(4);
        check(int'(a_y) == 0, "R7 zero history", int'(a_y), 0);
    endtask

    task automatic t_stream();
        for (int i = 0; i < 40; i++) push(8'($urandom));
        idle(4);
        for (int i = 0; i < 30; i++) begin
            push(8'($urandom));
            if (i % 3 == 0) idle(1 + (i % 2));
        end
        idle(5);
    endtask

    task automatic t_mid_reset();
        push(8'd100);
        push(8'd55);
        idle(5);
        @(negedge clk);
        rst = 1'b1;
        @(negedge clk);
        @(negedge clk);
        rst = 1'b0;
        for (int k = 0; k < 4; k++) hist[k] = 0;
        check(a_valid == 1'b0, "R1 valid low after reset", int'(a_valid), 0);
        push(8'hF6);   // R1: expect a(0) * -10 only
        idle(5);
    endtask

    initial begin
        #(CLK_PERIOD * 100000);
        errors++;
        $display("FAIL watchdog expired actual=running expected=done");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        t_reset_state();
        t_latency();
        idle(2);
        t_hold();
        t_extremes();
        t_zero();
        t_stream();
        t_mid_reset();
        idle(4);
        check(qa.size() == 0, "R2 all pulses seen", qa.size(), 0);
        check(qb.size() == 0, "R2 all pulses seen split", qb.size(), 0);
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule